// File: doc/BRIEF.md
# Preloadable Timer / Event Counter

An 8-bit up-counter that either times a divided-down copy of the system clock or counts edges on an external input pin. Software sets it up through a small register port with three locations: a control byte, the count register, and an interrupt control byte. The count register is read to sample the count and written to set the reload value. When the count passes 0xFF it reloads from the reload register and sets an interrupt request flag. That flag is combined with two enables to drive an interrupt line.

A separate wake-up output serves a low-power controller. It pulses on any overflow that happens while the power-down input is high, whatever the interrupt enables are. It stays quiet if the request flag was already set when the overflow happened. This lets software block a wake-up by setting the flag by hand before it powers down. In edge-counting mode the counter keeps running during power-down. Any cycle that reads the count or writes the reload register blocks the count clock, and a count step that falls in such a cycle is dropped.

Top module: `tmr_evt_cnt`

## Requirements
- R1: After reset, all three registers read 0x00, and `irq_o` and `wake_o` are low.
- R2: The control byte at address 0 has these fields: [7:6] mode, [5] edge select, [4] run enable, [3] spare, [2:0] divider select n. With mode 2'b10 and run enable set, the count advances by one every 2^(n+1) clocks. The divider restarts from zero whenever counting is stopped.
- R3: The count holds when bit 4 of the control byte is clear, or when the mode is 2'b00 or 2'b11. Setting bit 4 starts counting and clearing it stops counting.
- R4: With mode 2'b01, the count advances once per selected edge of `evt_i`: rising when bit 5 is 0, falling when bit 5 is 1. The input passes through a two-flop synchroniser before edge detection.
- R5: A count step taken from 0xFF loads the reload value instead of 0x00, and sets the request flag (bit 2 of address 2).
- R6: A write to address 1 stores the reload value. If counting is stopped, the same write also loads the count. If counting is running, the count is left as it is.
- R7: In any cycle with a read or a write at address 1, the count does not step. A step due in that cycle is lost, not deferred.
- R8: `irq_o` is high exactly when the request flag (bit 2), the counter interrupt enable (bit 1) and the master enable (bit 0) of address 2 are all set.
- R9: An overflow while `pdn_i` is high gives a one-cycle pulse on `wake_o` in the cycle after the overflow, whatever the enables are.
- R10: No wake-up pulse follows an overflow if the request flag was already set, or if `pdn_i` was low.
- R11: Software writes bit 2 of address 2 to set or clear the request flag. An overflow in the same cycle as such a write leaves the flag set.
- R12: Register reads are combinational: address 0 returns the control byte, address 1 the count, address 2 {5'b0, flag, counter enable, master enable}, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| evt_i | input | 1 | External event input, asynchronous |
| pdn_i | input | 1 | Device is in power-down |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-cycle wake-up pulse |

## Verification
The assertions check on every cycle the following. An overflow sets the flag and reloads the count. A cycle that accesses the count leaves a running count unchanged. A stopped count never moves unless a reload write loads it. A wake-up pulse lasts one cycle and needs power-down in the previous cycle. A set flag blocks the next pulse. The divider never produces back-to-back ticks above divide-by-two. Only the bench scenarios can show the counting rate itself: step counts over random divider settings and run lengths, edge polarity on the event pin, and the lost steps when the count is read. The same goes for reload writes that do or do not load the count, the interrupt gating, and the suppression of wake-up by a flag set in software.

// File: rtl/tec_pkg.sv
package tec_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INTC = 2'd2;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_RSVD  = 2'b11
  } tec_mode_e;

  typedef struct packed {
    tec_mode_e  mode;
    logic       edge_fall;
    logic       run_en;
    logic       spare;
    logic [2:0] psel;
  } tec_ctrl_t;

  localparam int INTC_MIE_BIT  = 0;
  localparam int INTC_TIE_BIT  = 1;
  localparam int INTC_FLAG_BIT = 2;

endpackage

// File: rtl/tec_rst_sync.sv
module tec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/tec_evt_edge.sv
module tec_evt_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic fall_sel_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise, fall;

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = evt_i;
    end else begin : g_next
      assign stage_d = sync_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  always_comb begin
    rise   = sync_q[STAGES-1] & ~last_q;
    fall   = ~sync_q[STAGES-1] & last_q;
    edge_o = fall_sel_i ? fall : rise;
  end

endmodule

// File: rtl/tec_prescaler.sv
module tec_prescaler #(
  parameter int PSEL_W = 3,
  localparam int PRE_W = 1 << PSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o
);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [PRE_W-1:0]  mask;
  logic [PSEL_W:0]   shamt;

  always_comb begin
    shamt  = {1'b0, psel_i} + 1'b1;
    mask   = ~({PRE_W{1'b1}} << shamt);
    tick_o = run_i && ((pre_q & mask) == mask);
    pre_d  = run_i ? pre_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: above divide-by-two a tick is never followed by another at once
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && run_i && psel_i != '0) |=>
      (!tick_o || !run_i || psel_i != $past(psel_i)));

endmodule

// File: rtl/tmr_evt_cnt.sv
module tmr_evt_cnt
  import tec_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              evt_i,
  input  logic              pdn_i,
  output logic              irq_o,
  output logic              wake_o
);

  localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};

  logic rst_n;

  tec_ctrl_t         ctrl_q, ctrl_d;
  logic [DATA_W-1:0] preload_q, preload_d;
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              mie_q, mie_d, tie_q, tie_d, flag_q, flag_d;
  logic              wake_q, wake_d;

  logic ctrl_wr, cnt_wr, intc_wr, cnt_acc;
  logic run, pre_tick, evt_edge, tick, step, ovf;

  tec_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  // register access decode
  always_comb begin
    ctrl_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_CTRL);
    cnt_wr  = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_CNT);
    intc_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_INTC);
    cnt_acc = bus_sel_i && (bus_wr_i || bus_rd_i) && (bus_addr_i == ADDR_CNT);
  end

  always_comb begin
    run = ctrl_q.run_en &&
          (ctrl_q.mode == MODE_TIMER || ctrl_q.mode == MODE_EVENT);
  end

  tec_prescaler #(.PSEL_W(3)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run && ctrl_q.mode == MODE_TIMER),
    .psel_i (ctrl_q.psel),
    .tick_o (pre_tick)
  );

  tec_evt_edge #(.STAGES(SYNC_STAGES)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .fall_sel_i (ctrl_q.edge_fall),
    .edge_o     (evt_edge)
  );

  // counter next state
  always_comb begin
    tick = (ctrl_q.mode == MODE_TIMER) ? pre_tick : evt_edge;
    step = run && tick && !cnt_acc;
    ovf  = step && (cnt_q == CNT_MAX);
    cnt_d = cnt_q;
    if (ovf)               cnt_d = preload_q;
    else if (step)         cnt_d = cnt_q + 1'b1;
    else if (cnt_wr && !run) cnt_d = bus_wdata_i;
  end

  // register next state
  always_comb begin
    ctrl_d    = ctrl_wr ? tec_ctrl_t'(bus_wdata_i) : ctrl_q;
    preload_d = cnt_wr ? bus_wdata_i : preload_q;
    mie_d     = intc_wr ? bus_wdata_i[INTC_MIE_BIT] : mie_q;
    tie_d     = intc_wr ? bus_wdata_i[INTC_TIE_BIT] : tie_q;
    flag_d    = flag_q;
    if (ovf)          flag_d = 1'b1;
    else if (intc_wr) flag_d = bus_wdata_i[INTC_FLAG_BIT];
    wake_d    = ovf && pdn_i && !flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      preload_q <= '0;
      cnt_q     <= '0;
      mie_q     <= 1'b0;
      tie_q     <= 1'b0;
      flag_q    <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      preload_q <= preload_d;
      cnt_q     <= cnt_d;
      mie_q     <= mie_d;
      tie_q     <= tie_d;
      flag_q    <= flag_d;
      wake_q    <= wake_d;
    end
  end

  // read mux and outputs
  always_comb begin
    unique case (bus_addr_i)
      ADDR_CTRL: bus_rdata_o = ctrl_q;
      ADDR_CNT:  bus_rdata_o = cnt_q;
      ADDR_INTC: bus_rdata_o = {{(DATA_W-3){1'b0}}, flag_q, tie_q, mie_q};
      default:   bus_rdata_o = '0;
    endcase
  end

  assign irq_o  = flag_q && tie_q && mie_q;
  assign wake_o = wake_q;

  // R5: overflow sets the request flag and reloads the count
  a_r5_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);
  a_r5_ovf_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(preload_q));

  // R7: a running count never moves in a cycle that touches it
  a_r7_access_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_acc && run) |=> $stable(cnt_q));

  // R3: a stopped count only moves through a reload write
  a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt_q));

  // R9: wake-up is one cycle long and follows a power-down cycle
  a_r9_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  a_r9_wake_pdn: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(pdn_i));

  // R10: a flag that is already set blocks the next wake-up
  a_r10_flag_blocks_wake: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> !wake_o);

endmodule

// File: tb/tb_tmr_evt_cnt.sv
`timescale 1ns/1ps
module tb_tmr_evt_cnt;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       bus_sel, bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       evt, pdn, irq, wake;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  int wake_long = 0;
  logic wake_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_evt_cnt dut (
    .clk(clk), .rst_ni(rst_ni),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .evt_i(evt), .pdn_i(pdn), .irq_o(irq), .wake_o(wake)
  );

  always @(negedge clk) begin
    if (wake) wake_cnt++;
    if (wake && wake_prev) wake_long++;
    wake_prev <= wake;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a negedge; each bus access spans one posedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      evt = 1; idle(4);
      evt = 0; idle(4);
    end
  endtask

  // expected {overflow, count} after inc steps starting from preload p
  function automatic logic [8:0] model(input logic [7:0] p, input int inc);
    logic [7:0] c = p;
    logic ov = 0;
    for (int i = 0; i < inc; i++) begin
      if (c == 8'hFF) begin c = p; ov = 1; end
      else c = c + 1;
    end
    return {ov, c};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [8:0] m;
    bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    evt = 0; pdn = 0;
    rst_ni = 0;
    repeat (5) @(posedge clk);
    rst_ni = 1;
    idle(5);

    // R1 / R12 reset values
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd1, d); check("R1 count", d, 0);
    rd(2'd2, d); check("R1 intc", d, 0);
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);

    // R12 map readback
    wr(2'd0, 8'h2B); rd(2'd0, d); check("R12 ctrl readback", d, 8'h2B);
    rd(2'd3, d); check("R12 unused address", d, 0);
    wr(2'd0, 8'h00);

    // R6 reload write while stopped loads the count
    wr(2'd1, 8'h5A); rd(2'd1, d); check("R6 load when stopped", d, 8'h5A);

    // R3 enable bit clear, and mode 00 with enable
    wr(2'd0, 8'h81); idle(30); rd(2'd1, d); check("R3 enable clear holds", d, 8'h5A);
    wr(2'd0, 8'h10); idle(30); rd(2'd1, d); check("R3 mode off holds", d, 8'h5A);
    wr(2'd0, 8'h00);

    // R2 directed: divide by 2 for 10 clocks
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h90); idle(9); wr(2'd0, 8'h00);
    rd(2'd1, d); check("R2 divide by two", d, 8'h15);

    // R7 reads during every would-be tick lose the steps
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h90);
    for (int i = 0; i < 10; i++) rd(2'd1, d);
    wr(2'd0, 8'h00);
    rd(2'd1, d); check("R7 reads drop steps", d, 8'h10);

    // R6 reload write while running leaves the count
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h90); wr(2'd1, 8'h80); idle(7); wr(2'd0, 8'h00);
    rd(2'd1, d); check("R6 running write keeps count", d, 8'h24);

    // R2 / R5 random divider settings and run lengths
    void'($urandom(32'd20240611));
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p;
      int n, len;
      p   = 8'($urandom_range(0, 255));
      n   = $urandom_range(0, 3);
      len = $urandom_range(1, 400);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd1, p);
      wr(2'd0, 8'h90 | 8'(n));
      idle(len - 1);
      wr(2'd0, 8'h00);
      m = model(p, len / (1 << (n + 1)));
      rd(2'd1, d); check("R2 random count", d, int'(m[7:0]));
      rd(2'd2, d); check("R5 random flag", d[2], m[8]);
    end

    // R4 rising edges
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h30);
    wr(2'd0, 8'h50); pulse(5); idle(4); wr(2'd0, 8'h00);
    rd(2'd1, d); check("R4 rising edges", d, 8'h35);

    // R4 falling select: a rise alone does not count
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h70);
    evt = 1; idle(6); rd(2'd1, d); check("R4 rise ignored in falling mode", d, 8'h40);
    evt = 0; idle(6); rd(2'd1, d); check("R4 fall counted", d, 8'h41);
    wr(2'd0, 8'h00);

    // R5 / R8 overflow through events, irq gating
    wr(2'd2, 8'h03);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'h50); pulse(2); wr(2'd0, 8'h00);
    rd(2'd1, d); check("R5 reload on overflow", d, 8'hFE);
    rd(2'd2, d); check("R5 flag set", d[2], 1);
    check("R8 irq all set", irq, 1);
    wr(2'd2, 8'h05); check("R8 irq without counter enable", irq, 0);
    wr(2'd2, 8'h06); check("R8 irq without master", irq, 0);
    wr(2'd2, 8'h07); check("R11 software set drives irq", irq, 1);
    wr(2'd2, 8'h03); check("R11 software clear", irq, 0);

    // R11 overflow wins over a same-cycle clear
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h90); idle(1); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    rd(2'd2, d); check("R11 overflow beats clear", d[2], 1);

    // R9 wake-up with every enable off
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hFF);
    pdn = 1;
    wr(2'd0, 8'h50); pulse(1);
    check("R9 wake during power-down", wake_cnt, 1);
    check("R9 wake single cycle", wake_long, 0);
    check("R9 no irq with enables off", irq, 0);

    // R10 flag already set blocks wake-up
    pulse(1);
    check("R10 flag set blocks wake", wake_cnt, 1);
    rd(2'd1, d); check("R10 count kept running", d, 8'hFF);

    // R10 no wake-up outside power-down
    wr(2'd2, 8'h00);
    pdn = 0;
    pulse(1);
    check("R10 no wake without power-down", wake_cnt, 1);
    rd(2'd2, d); check("R10 overflow still flagged", d[2], 1);
    wr(2'd0, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule